// File: doc/BRIEF.md
# Shadow RAM Segment Attribute Decoder

The decoder covers the upper 384 KB of the first megabyte of a 286-class memory map. That region runs from 0xA0000 to 0xFFFFF and is split into 24 segments of 16 KB. The decoder holds three shadow-enable bytes and one write-protect byte. From these bytes and the current CPU address, it decides how the addressed segment is reached:

- A read goes either to the on-board DRAM (internal) or to the expansion bus (external).
- A write goes to internal DRAM, goes to the external bus, or is discarded.

Firmware loads the configuration bytes through a small write port. It does this to copy ROM into DRAM, then run from DRAM and lock the copy against writes. The routing outputs are combinational. The configuration bytes are registered, so a byte written on one clock edge governs every access from the following cycle on.

The lowest eight segments (0xA0000–0xBFFFF) are never write-protected. The other sixteen segments are protected in pairs, with one protect bit per pair. A discarded write still finishes on the bus, but the decoder raises a discard flag so that no memory is changed.

Top module: `shadow_seg_decoder`

## Requirements
- R1: `in_window` is high exactly when `cpu_addr` lies in 0xA0000–0xFFFFF. For addresses below 0xA0000, none of the five route outputs is asserted.
- R2: Segment i (0..23) covers page `cpu_addr[19:14]` = 40+i. Its enable bit is bit (i mod 8) of shadow bank (i div 8). Bank k is loaded by a write with `cfg_sel` = k, for k = 0, 1, 2.
- R3: While `cpu_rd` is high in the window, `rd_int` is asserted if the segment's enable bit is 1, and `rd_ext` is asserted if it is 0. The protect byte never affects reads.
- R4: Writes to segments 0..7 follow the enable bit (`wr_int` when set, `wr_ext` when clear) and are never discarded, whatever the protect byte holds.
- R5: For segments 8..23, the protect bit is bit ((i-8) div 2) of the protect byte, which is loaded with `cfg_sel` = 3. When that bit is 1, a write asserts only `wr_discard`, whatever the enable bit holds.
- R6: For segments 8..23 whose protect bit is 0, writes follow the enable bit (`wr_int` when set, `wr_ext` when clear).
- R7: Reset clears all four configuration bytes, so every segment routes reads and writes externally until it is reconfigured.
- R8: A configuration write on a clock edge governs the outputs from that edge on, with no further delay. With both strobes low, no route output is asserted.
- R9: At most one of `rd_int`/`rd_ext` is high at a time. At most one of `wr_int`/`wr_ext`/`wr_discard` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 2 | Target byte: 0..2 shadow banks, 3 protect byte |
| cfg_data | input | 8 | Configuration byte value |
| cpu_addr | input | 20 | CPU address |
| cpu_rd | input | 1 | Memory read strobe |
| cpu_wr | input | 1 | Memory write strobe |
| in_window | output | 1 | Address falls in the 24-segment window |
| rd_int | output | 1 | Read served by internal DRAM |
| rd_ext | output | 1 | Read served by the external bus |
| wr_int | output | 1 | Write goes to internal DRAM |
| wr_ext | output | 1 | Write goes to the external bus |
| wr_discard | output | 1 | Write completes on the bus but is discarded |

## Verification
For each configuration tried, the bench walks every one of the 64 possible 16 KB pages under all four strobe combinations and compares the outputs against an arithmetic model.

The configurations tried, and what each one tells apart:
- **All zero after reset:** checks the external default.
- **All enables set, with and without full protection:** separates the never-protected lower eight segments from the paired ones.
- **Walking single bits through each bank and through the protect byte:** exposes any mix-up in bit position, bank order or pair grouping.
- **Complementary and random bytes:** catch interactions between the enable and protect bits.

// File: rtl/shadow_seg_decoder.sv
module shadow_seg_decoder #(
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 14,
  parameter int SEG_BASE  = 40,
  parameter int SEG_CNT   = 24,
  parameter int FIXED_CNT = 8,
  parameter int PAIR_SZ   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [7:0]  cfg_data,
  input  logic [19:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  output logic        in_window,
  output logic        rd_int,
  output logic        rd_ext,
  output logic        wr_int,
  output logic        wr_ext,
  output logic        wr_discard
);
  localparam int BANK_W = 8;
  localparam int BANKS  = SEG_CNT / BANK_W;
  localparam int PROT_W = (SEG_CNT - FIXED_CNT) / PAIR_SZ;
  localparam int PAGE_W = ADDR_W - SEG_SHIFT;

  logic [BANK_W-1:0]  shadow_q [BANKS];
  logic [PROT_W-1:0]  prot_q;
  logic [SEG_CNT-1:0] en_vec, wp_vec, seg_hot;
  logic [PAGE_W-1:0]  page;
  logic               sel_en, sel_wp;

  genvar b, s;
  generate
    for (b = 0; b < BANKS; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (!rst_n)
          shadow_q[b] <= '0;
        else if (cfg_we && cfg_sel == 2'(b))
          shadow_q[b] <= cfg_data;
      end
      assign en_vec[b*BANK_W +: BANK_W] = shadow_q[b];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)
      prot_q <= '0;
    else if (cfg_we && cfg_sel == 2'(BANKS))
      prot_q <= cfg_data[PROT_W-1:0];
  end

  assign page = cpu_addr[ADDR_W-1:SEG_SHIFT];

  generate
    for (s = 0; s < SEG_CNT; s++) begin : g_seg
      assign seg_hot[s] = (page == PAGE_W'(SEG_BASE + s));
      if (s < FIXED_CNT) begin : g_fixed
        assign wp_vec[s] = 1'b0;
      end else begin : g_paired
        assign wp_vec[s] = prot_q[(s - FIXED_CNT) / PAIR_SZ];
      end
    end
  endgenerate

  assign in_window = |seg_hot;
  assign sel_en    = |(en_vec & seg_hot);
  assign sel_wp    = |(wp_vec & seg_hot);

  assign rd_int     = cpu_rd & sel_en;
  assign rd_ext     = cpu_rd & in_window & ~sel_en;
  assign wr_discard = cpu_wr & sel_wp;
  assign wr_int     = cpu_wr & ~sel_wp & sel_en;
  assign wr_ext     = cpu_wr & in_window & ~sel_wp & ~sel_en;
endmodule

// File: rtl/shadow_seg_decoder_chk.sv
module shadow_seg_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [1:0]  cfg_sel,
  input logic [7:0]  cfg_data,
  input logic [19:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic        in_window,
  input logic        rd_int,
  input logic        rd_ext,
  input logic        wr_int,
  input logic        wr_ext,
  input logic        wr_discard
);
  p_window_bounds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_window == (cpu_addr >= 20'hA0000));

  p_no_route_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_window |-> !(rd_int || rd_ext || wr_int || wr_ext || wr_discard));

  p_read_served_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && in_window) |-> (rd_int || rd_ext));

  p_low_never_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[19:14] < 6'd48) |-> !wr_discard);

  p_write_served_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && in_window) |-> (wr_int || wr_ext || wr_discard));

  p_reset_external_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !(rd_int || wr_int || wr_discard));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rd && !cpu_wr) |-> !(rd_int || rd_ext || wr_int || wr_ext || wr_discard));

  p_hold_without_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cfg_we) && $stable(cpu_addr) && $stable(cpu_rd) && $stable(cpu_wr))
      |-> ($stable(rd_int) && $stable(wr_int) && $stable(wr_discard)));

  p_rd_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_int, rd_ext}));

  p_wr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_int, wr_ext, wr_discard}));
endmodule

bind shadow_seg_decoder shadow_seg_decoder_chk chk_i (.*);

// File: tb/shadow_seg_decoder_test.sv
module shadow_seg_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [7:0]  cfg_data = 0;
  logic [19:0] cpu_addr = 0;
  logic        cpu_rd = 0;
  logic        cpu_wr = 0;
  logic        in_window, rd_int, rd_ext, wr_int, wr_ext, wr_discard;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] m_sh [3];
  logic [7:0] m_pr;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_seg_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .in_window(in_window), .rd_int(rd_int), .rd_ext(rd_ext),
    .wr_int(wr_int), .wr_ext(wr_ext), .wr_discard(wr_discard)
  );

  function automatic logic [5:0] model(input int page, input bit rd, input bit wr);
    bit win, en, wp;
    int seg;
    win = (page >= 40) && (page < 64);
    seg = page - 40;
    en  = win ? m_sh[seg / 8][seg % 8] : 1'b0;
    wp  = (win && seg >= 8) ? m_pr[(seg - 8) / 2] : 1'b0;
    return {win, rd & en, rd & win & ~en, wr & ~wp & en, wr & win & ~wp & ~en, wr & wp};
  endfunction

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_data = data;
    @(negedge clk);
    cfg_we = 0;
    if (sel == 2'd3) m_pr = data; else m_sh[sel] = data;
  endtask

  task automatic sweep(input string phase);
    for (int page = 0; page < 64; page++) begin
      for (int mode = 0; mode < 4; mode++) begin
        logic [5:0] exp_v, got_v;
        string tag;
        int seg;
        seg = page - 40;
        cpu_addr = {6'(page), 14'((page * 1237) & 16'h3FFF)};
        cpu_rd = mode[0];
        cpu_wr = mode[1];
        #1;
        exp_v = model(page, mode[0], mode[1]);
        got_v = {in_window, rd_int, rd_ext, wr_int, wr_ext, wr_discard};
        if (page < 40) tag = "R1";
        else if (mode == 0) tag = "R8";
        else if (mode[1] && seg < 8) tag = "R4";
        else if (mode[1] && m_pr[(seg - 8) / 2]) tag = "R5";
        else if (mode[1]) tag = "R6";
        else tag = "R3";
        compared++;
        if (got_v !== exp_v) begin
          mismatched++;
          $display("FAIL %s/%s page=%0d rd=%0b wr=%0b actual=%b expected=%b",
                   tag, phase, page, mode[0], mode[1], got_v, exp_v);
        end
        compared++;
        if ($countones({rd_int, rd_ext}) > 1 || $countones({wr_int, wr_ext, wr_discard}) > 1) begin
          mismatched++;
          $display("FAIL R9/%s page=%0d actual=%b expected=one-hot routes", phase, page, got_v);
        end
      end
    end
    cpu_rd = 0; cpu_wr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) m_sh[k] = 8'h00;
    m_pr = 8'h00;
    cfg_we = 1; cfg_sel = 2'd0; cfg_data = 8'hFF;
    repeat (3) @(negedge clk);
    cfg_we = 0;
    rst_n = 1;
    // R7: reset state, a write held during reset must not stick
    sweep("R7");

    for (int k = 0; k < 3; k++) cfg_write(2'(k), 8'hFF);
    sweep("R3_all_enabled");
    cfg_write(2'd3, 8'hFF);
    sweep("R5_all_protected");

    for (int k = 0; k < 3; k++) cfg_write(2'(k), 8'h00);
    cfg_write(2'd3, 8'h00);
    for (int k = 0; k < 3; k++) begin
      for (int bit_i = 0; bit_i < 8; bit_i++) begin
        cfg_write(2'(k), 8'(1 << bit_i));
        sweep("R2_walk_enable");
      end
      cfg_write(2'(k), 8'h00);
    end
    for (int bit_i = 0; bit_i < 8; bit_i++) begin
      cfg_write(2'd3, 8'(1 << bit_i));
      sweep("R5_walk_protect");
    end

    cfg_write(2'd0, 8'h55); cfg_write(2'd1, 8'hAA); cfg_write(2'd2, 8'h5A);
    cfg_write(2'd3, 8'h0F);
    sweep("R6_mixed");

    for (int n = 0; n < 8; n++) begin
      for (int k = 0; k < 4; k++) cfg_write(2'(k), 8'($urandom));
      sweep("R6_random");
    end

    // R8: a write followed at once by an access in the next cycle
    cfg_write(2'd2, 8'h80);
    cpu_addr = 20'hFC000; cpu_rd = 1;
    #1;
    compared++;
    if (rd_int !== 1'b1) begin
      mismatched++;
      $display("FAIL R8 rd_int actual=%b expected=1", rd_int);
    end
    cpu_rd = 0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule